// File: doc/BRIEF.md
# Subcode Symbol and Sync Detector

This block sits behind an IEC958 audio receiver and works on the user-channel bit stream, which arrives as one bit per frame strobe. It finds 8-bit data symbols, each marked by a leading 1. Between two symbols it counts the run of 0 bits. Sync symbols never appear as bit patterns on this stream. The block works out how many of them passed by sorting the length of each zero run into a bin.

Each completed symbol is reported with a one-cycle strobe and its 8-bit value. Each pause that ends in a leading 1 gives one of two results. A legal pause gives a one-cycle sync strobe with a count from 0 to 3. A pause that is too short or too long gives an illegal-pause pulse instead. On average the transmitter sends one symbol every 12 user bits, within 5%. The bins are wide enough to absorb that drift. Packet assembly, data-value checking and biphase decoding belong to other blocks.

Top module: `subcode_sync_detector`

## Requirements
- R1: While reset is held, and on the first sample after it, `sym_vld`, `sync_vld` and `pause_err` are 0, and `sym_data` and `sync_cnt` are 0.
- R2: A symbol is a 1 followed by 7 information bits, taken MSB first. One clock after the strobe that carries the 8th bit, `sym_vld` pulses for one cycle. `sym_data` then holds the 8 bits with the leading 1 in bit 7.
- R3: The bit input is taken only in a cycle where `bit_vld` is 1. In a cycle without a strobe, all three output strobes stay 0 one clock later, and no internal count moves.
- R4: A pause of 2 to 10 zero bits ends with `sync_vld` set and `sync_cnt` = 0.
- R5: A pause of 11 to 22 zeros gives `sync_cnt` = 1. A pause of 23 to 34 gives 2. A pause of 35 to 45 gives 3. Each comes with a `sync_vld` pulse.
- R6: A pause of 0 or 1 zero bits pulses `pause_err`, and `sync_vld` stays 0.
- R7: A pause of 46 or more zeros, of any length, pulses `pause_err` and gives no sync count. The zero counter saturates and does not wrap.
- R8: The sync or illegal-pause result comes one clock after the strobe that carries the next leading 1. That symbol's `sym_vld` follows 7 strobes later.
- R9: After reset, every 1 is ignored until one arrives after at least 2 zero bits. That first symbol is captured but gives neither a sync result nor `pause_err`.
- R10: `sync_vld` and `pause_err` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Frame strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | User-channel bit |
| sym_vld | output | 1 | One-cycle pulse: a symbol has completed |
| sym_data | output | 8 | Last completed symbol, MSB received first |
| sync_vld | output | 1 | One-cycle pulse: a legal pause has ended |
| sync_cnt | output | 2 | Number of sync symbols inferred from that pause |
| pause_err | output | 1 | One-cycle pulse: the pause that ended was illegal |

## Verification
Some rules are checked by assertions on every cycle:
- the sync and error pulses never come together;
- every completed symbol has a 1 in bit 7;
- no output pulse appears without a strobe one cycle before;
- a sync or error result is never followed at once by a symbol strobe.

Other rules only the bench scenarios can show: the exact bin edges at 1/2, 10/11, 22/23, 34/35 and 45/46, saturation on a very long pause, and the way reset hunting ignores early ones. The bench shows these by comparing pauses and symbol values against a model held in the bench.

// File: rtl/scd_pkg.sv
package scd_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_GAP  = 2'd1,
        ST_DATA = 2'd2
    } scd_state_e;

    localparam int DEF_SYM_W   = 8;
    localparam int DEF_MIN_GAP = 2;
    localparam int DEF_LIM0    = 10;
    localparam int DEF_LIM1    = 22;
    localparam int DEF_LIM2    = 34;
    localparam int DEF_LIM3    = 45;
    localparam int SYNC_W      = 2;
endpackage

// File: rtl/scd_zero_run.sv
module scd_zero_run #(
    parameter int ZSAT = 46,
    parameter int ZW   = $clog2(ZSAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [ZW-1:0] zeros
);
    localparam logic [ZW-1:0] SAT_V = ZW'(ZSAT);

    logic [ZW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != SAT_V)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zeros = cnt_q;
endmodule

// File: rtl/scd_gap_bin.sv
module scd_gap_bin
    import scd_pkg::*;
#(
    parameter int ZW      = 6,
    parameter int MIN_GAP = DEF_MIN_GAP,
    parameter int LIM0    = DEF_LIM0,
    parameter int LIM1    = DEF_LIM1,
    parameter int LIM2    = DEF_LIM2,
    parameter int LIM3    = DEF_LIM3
) (
    input  logic [ZW-1:0]     zeros,
    output logic              legal,
    output logic [SYNC_W-1:0] nsync
);
    localparam int NBND = 3;
    localparam int BND [NBND] = '{LIM0, LIM1, LIM2};

    logic [NBND-1:0] above;

    for (genvar i = 0; i < NBND; i++) begin : g_bnd
        assign above[i] = (zeros > ZW'(BND[i]));
    end

    always_comb begin
        nsync = '0;
        for (int i = 0; i < NBND; i++) begin
            nsync = nsync + SYNC_W'(above[i]);
        end
        legal = (zeros >= ZW'(MIN_GAP)) && (zeros <= ZW'(LIM3));
    end
endmodule

// File: rtl/scd_sym_shift.sv
module scd_sym_shift #(
    parameter int SYM_W = 8,
    parameter int CW    = $clog2(SYM_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             din,
    output logic             last,
    output logic [SYM_W-1:0] word
);
    typedef struct packed {
        logic [SYM_W-2:0] sh;
        logic [CW-1:0]    nb;
    } shr_t;

    shr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.sh = {{(SYM_W-2){1'b0}}, 1'b1};
            r_d.nb = '0;
        end else if (shift) begin
            r_d.sh = {r_q.sh[SYM_W-3:0], din};
            r_d.nb = r_q.nb + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign last = (r_q.nb == CW'(SYM_W - 2));
    assign word = {r_q.sh, din};
endmodule

// File: rtl/subcode_sync_detector.sv
module subcode_sync_detector
    import scd_pkg::*;
#(
    parameter int SYM_W   = DEF_SYM_W,
    parameter int MIN_GAP = DEF_MIN_GAP,
    parameter int LIM0    = DEF_LIM0,
    parameter int LIM1    = DEF_LIM1,
    parameter int LIM2    = DEF_LIM2,
    parameter int LIM3    = DEF_LIM3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              sym_vld,
    output logic [SYM_W-1:0]  sym_data,
    output logic              sync_vld,
    output logic [SYNC_W-1:0] sync_cnt,
    output logic              pause_err
);
    localparam int ZSAT = LIM3 + 1;
    localparam int ZW   = $clog2(ZSAT + 1);

    typedef struct packed {
        scd_state_e        state;
        logic              sym_vld;
        logic [SYM_W-1:0]  sym_data;
        logic              sync_vld;
        logic [SYNC_W-1:0] sync_cnt;
        logic              pause_err;
    } top_t;

    top_t q, d;

    logic              zc_clr, zc_inc;
    logic [ZW-1:0]     zeros;
    logic              gap_legal;
    logic [SYNC_W-1:0] gap_nsync;
    logic              sh_load, sh_shift, sh_last;
    logic [SYM_W-1:0]  sh_word;

    scd_zero_run #(.ZSAT(ZSAT), .ZW(ZW)) u_zrun (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (zc_clr),
        .inc   (zc_inc),
        .zeros (zeros)
    );

    scd_gap_bin #(
        .ZW(ZW), .MIN_GAP(MIN_GAP),
        .LIM0(LIM0), .LIM1(LIM1), .LIM2(LIM2), .LIM3(LIM3)
    ) u_bin (
        .zeros (zeros),
        .legal (gap_legal),
        .nsync (gap_nsync)
    );

    scd_sym_shift #(.SYM_W(SYM_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (bit_in),
        .last  (sh_last),
        .word  (sh_word)
    );

    always_comb begin
        d           = q;
        d.sym_vld   = 1'b0;
        d.sync_vld  = 1'b0;
        d.pause_err = 1'b0;
        zc_clr      = 1'b0;
        zc_inc      = 1'b0;
        sh_load     = 1'b0;
        sh_shift    = 1'b0;
        if (bit_vld) begin
            unique case (q.state)
                ST_HUNT: begin
                    if (!bit_in) begin
                        zc_inc = 1'b1;
                    end else begin
                        zc_clr = 1'b1;
                        if (zeros >= ZW'(MIN_GAP)) begin
                            sh_load = 1'b1;
                            d.state = ST_DATA;
                        end
                    end
                end
                ST_GAP: begin
                    if (!bit_in) begin
                        zc_inc = 1'b1;
                    end else begin
                        zc_clr  = 1'b1;
                        sh_load = 1'b1;
                        d.state = ST_DATA;
                        if (gap_legal) begin
                            d.sync_vld = 1'b1;
                            d.sync_cnt = gap_nsync;
                        end else begin
                            d.pause_err = 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    sh_shift = 1'b1;
                    if (sh_last) begin
                        d.sym_vld  = 1'b1;
                        d.sym_data = sh_word;
                        d.state    = ST_GAP;
                        zc_clr     = 1'b1;
                    end
                end
                default: d.state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign sym_vld   = q.sym_vld;
    assign sym_data  = q.sym_data;
    assign sync_vld  = q.sync_vld;
    assign sync_cnt  = q.sync_cnt;
    assign pause_err = q.pause_err;
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
    parameter int SYM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic             bit_in,
    input logic             sym_vld,
    input logic [SYM_W-1:0] sym_data,
    input logic             sync_vld,
    input logic             pause_err
);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_vld && pause_err));

    a_r2_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> sym_data[SYM_W-1]);

    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |=> !sym_vld);

    a_r3_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld || sync_vld || pause_err) |-> $past(bit_vld));

    a_r8_on_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_vld || pause_err) |-> $past(bit_in));

    a_r8_before_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_vld || pause_err) |=> !sym_vld);
endmodule

bind subcode_sync_detector scd_checker #(.SYM_W(SYM_W)) u_scd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .sym_vld   (sym_vld),
    .sym_data  (sym_data),
    .sync_vld  (sync_vld),
    .pause_err (pause_err)
);

// File: tb/sim_subcode_sync_detector.sv
module sim_subcode_sync_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       sym_vld, sync_vld, pause_err;
    logic [7:0] sym_data;
    logic [1:0] sync_cnt;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // model state: 0 hunt, 1 gap, 2 data
    int         m_mode = 0;
    int         m_z = 0;
    int         m_n = 0;
    logic [7:0] m_w = '0;

    always #10 clk = ~clk;

    subcode_sync_detector u0 (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .sym_vld(sym_vld), .sym_data(sym_data), .sync_vld(sync_vld),
        .sync_cnt(sync_cnt), .pause_err(pause_err)
    );

    function automatic int bin_of(int z);
        if (z < 2 || z > 45) return -1;
        if (z <= 10) return 0;
        if (z <= 22) return 1;
        if (z <= 34) return 2;
        return 3;
    endfunction

    function automatic string tag_of(int z);
        if (z < 2)   return "R6";
        if (z > 45)  return "R7";
        if (z <= 10) return "R4";
        return "R5";
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input logic b, input bit strobe);
        int  e_sym = 0, e_sync = 0, e_err = 0, e_cnt = 0, bn;
        int  e_data = 0;
        bit  lead = 0;
        string t_res = "R3";
        bit_vld = strobe;
        bit_in  = b;
        if (strobe) begin
            case (m_mode)
                0: begin
                    t_res = "R9";
                    if (!b) m_z++;
                    else if (m_z >= 2) begin m_mode = 2; m_w = 8'd1; m_n = 1; m_z = 0; end
                    else m_z = 0;
                end
                1: begin
                    if (!b) begin
                        m_z++;
                        t_res = "R2";
                    end else begin
                        bn = bin_of(m_z);
                        t_res = tag_of(m_z);
                        if (bn < 0) e_err = 1;
                        else begin e_sync = 1; e_cnt = bn; end
                        lead = 1;
                        m_mode = 2; m_w = 8'd1; m_n = 1; m_z = 0;
                    end
                end
                default: begin
                    m_w = {m_w[6:0], b};
                    m_n++;
                    t_res = "R2";
                    if (m_n == 8) begin
                        e_sym = 1; e_data = int'(m_w); m_mode = 1; m_z = 0;
                    end
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(strobe ? "R2" : "R3", int'(sym_vld), e_sym);
        chk(t_res, int'(sync_vld), e_sync);
        chk(t_res, int'(pause_err), e_err);
        chk("R10", int'(sync_vld && pause_err), 0);
        if (e_sym) chk("R2", int'(sym_data), e_data);
        if (e_sync) chk(t_res, int'(sync_cnt), e_cnt);
        if (lead) begin
            chk("R8", int'(sym_vld), 0);
            chk("R8", int'(sync_vld || pause_err), 1);
        end
    endtask

    task automatic send_bit(input logic b, input bit idle_ok);
        if (idle_ok && ($urandom_range(0, 3) == 0)) tick($urandom_range(0, 1) == 1, 1'b0);
        tick(b, 1'b1);
    endtask

    task automatic send_zeros(int n, bit idle_ok);
        for (int i = 0; i < n; i++) send_bit(1'b0, idle_ok);
    endtask

    task automatic send_sym(logic [6:0] info, bit idle_ok);
        send_bit(1'b1, idle_ok);
        for (int i = 6; i >= 0; i--) send_bit(info[i], idle_ok);
    endtask

    initial begin
        int edges [12] = '{0, 1, 2, 10, 11, 22, 23, 34, 35, 45, 46, 100};
        void'($urandom(32'd5177));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(sym_vld), 0);
        chk("R1", int'(sync_vld), 0);
        chk("R1", int'(pause_err), 0);
        chk("R1", int'(sym_data), 0);
        chk("R1", int'(sync_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(sym_vld || sync_vld || pause_err), 0);
        // R9: early ones are ignored, then hunting ends
        send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        send_zeros(2, 0);
        send_sym(7'h25, 0);
        // R4 R5 R6 R7: bin edges, strobe-less cycles mixed in for R3
        foreach (edges[k]) begin
            send_zeros(edges[k], 1);
            send_sym(7'($urandom_range(0, 127)), 1);
        end
        // random pauses and data
        for (int s = 0; s < 250; s++) begin
            send_zeros($urandom_range(0, 60), 1);
            send_sym(7'($urandom_range(0, 127)), 1);
        end
        send_zeros(5, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule